// File: doc/BRIEF.md
# Subtract-With-Borrow Arithmetic Unit

This block is an 8-bit (parameterised) arithmetic unit that takes a minuend, a subtrahend and an incoming borrow bit. It produces the difference `minuend - subtrahend - borrow_in` together with six status flags. These are the borrow-out, zero, sign, signed overflow, a decimal-adjust marker and a nibble flag. The subtraction is performed by adding the inverted subtrahend to the minuend, with the inverted borrow injected as the carry into bit 0. The carry out of bit 3 and the carry out of the top bit then give the nibble flag and the borrow flag, each inverted.

The unit is meant to sit in a processor datapath as the multi-precision subtract slice. A wide subtraction is done by chaining the borrow output of one byte into the borrow input of the next byte. With the default configuration the result and flags are captured in an output register on a clock enable. When the enable is low, the last values are held, so an unselected unit leaves its flags unchanged. A parameter removes the register for a purely combinational variant.

Top module: `sbb_alu`

## Requirements
- R1: When `en_i` is high at a clock edge, `res_o` after that edge equals `(dst_i - src_i - cin_i)` modulo 256. For example, 10H, 03H and borrow 1 give 0CH.
- R2: `c_o` is 1 after an enabled edge exactly when the unsigned value of `dst_i` is less than `src_i + cin_i`, computed with 9 bits. This covers the case where `src_i` is FFH and `cin_i` is 1.
- R3: `z_o` is 1 after an enabled edge exactly when the 8-bit result is 00H.
- R4: `s_o` is 1 after an enabled edge exactly when result bit 7 is 1.
- R5: `v_o` is 1 after an enabled edge exactly when `dst_i[7]` differs from `src_i[7]` and result bit 7 equals `src_i[7]`. For example, 20H minus 8AH with borrow 1 gives 95H with `c_o`, `s_o` and `v_o` all 1.
- R6: `d_o` is 1 after every enabled edge, whatever the operands.
- R7: `h_o` is 0 when the low-nibble addition `dst_i[3:0] + ~src_i[3:0] + ~cin_i` carries out of bit 3, and 1 otherwise. Equivalently, `h_o` is 1 exactly when `dst_i[3:0] < src_i[3:0] + cin_i`.
- R8: When `en_i` is low at an edge (and `rst_i` is low), `res_o` and all six flags keep their previous values, whatever the operand inputs are.
- R9: When `rst_i` is high at an edge, `res_o` and all six flags become 0 after that edge. This is a synchronous reset.
- R10: The outputs change only at the clock edge. Inputs applied before an edge are not visible on the outputs until after that edge (one cycle of latency).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Capture enable for result and flags |
| dst_i | input | 8 | Minuend operand |
| src_i | input | 8 | Subtrahend operand |
| cin_i | input | 1 | Incoming borrow |
| res_o | output | 8 | Difference |
| c_o | output | 1 | Borrow out of the top bit |
| z_o | output | 1 | Result is zero |
| s_o | output | 1 | Result bit 7 |
| v_o | output | 1 | Signed overflow |
| d_o | output | 1 | Decimal-adjust marker, 1 after any operation |
| h_o | output | 1 | Inverted carry out of bit 3 (nibble borrow) |

## Verification
Every result and every flag is due exactly one clock after the edge at which `en_i` was sampled high. The bench drives operands just after a falling edge and compares all outputs at the next falling edge, which is half a period after the capturing rising edge. For the latency check it also samples before that rising edge, to confirm the outputs still show the previous operation. A table of hand-worked vectors covers the borrow, zero, overflow and nibble-borrow corners. It is followed by an exhaustive sweep of all operand pairs with both borrow values against an integer reference model. Hold and reset are checked by changing the operands while the enable is low, or while reset is high, and comparing the outputs one cycle later.

// File: rtl/sbb_pkg.sv
package sbb_pkg;

  typedef struct packed {
    logic c;
    logic z;
    logic s;
    logic v;
    logic d;
    logic h;
  } sbb_flags_t;

  localparam sbb_flags_t FLAGS_CLEAR = '{c: 1'b0, z: 1'b0, s: 1'b0,
                                         v: 1'b0, d: 1'b0, h: 1'b0};

endpackage

// File: rtl/sbb_addsub_core.sv
// Ripple adder computing a + ~b + ~bin, exposing the nibble and top carries.
module sbb_addsub_core #(
  parameter int WIDTH    = 8,
  parameter int HALF_BIT = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             bin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_half_o,
  output logic             carry_top_o
);

  logic [WIDTH:0]   chain;
  logic [WIDTH-1:0] b_inv;

  assign chain[0] = ~bin_i;
  assign b_inv    = ~b_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign sum_o[i]     = a_i[i] ^ b_inv[i] ^ chain[i];
    assign chain[i + 1] = (a_i[i] & b_inv[i]) | (a_i[i] & chain[i]) |
                          (b_inv[i] & chain[i]);
  end

  assign carry_half_o = chain[HALF_BIT];
  assign carry_top_o  = chain[WIDTH];

endmodule

// File: rtl/sbb_flag_gen.sv
module sbb_flag_gen
  import sbb_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             dst_msb_i,
  input  logic             src_msb_i,
  input  logic [WIDTH-1:0] sum_i,
  input  logic             carry_half_i,
  input  logic             carry_top_i,
  output sbb_flags_t       flags_o
);

  logic res_msb;
  assign res_msb = sum_i[WIDTH-1];

  always_comb begin
    flags_o.c = ~carry_top_i;
    flags_o.z = (sum_i == '0);
    flags_o.s = res_msb;
    flags_o.v = (dst_msb_i ^ src_msb_i) & ~(res_msb ^ src_msb_i);
    flags_o.d = 1'b1;
    flags_o.h = ~carry_half_i;
  end

endmodule

// File: rtl/sbb_out_stage.sv
module sbb_out_stage
  import sbb_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic [WIDTH-1:0] res_d_i,
  input  sbb_flags_t       flags_d_i,
  output logic [WIDTH-1:0] res_q_o,
  output sbb_flags_t       flags_q_o
);

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        res_q_o   <= '0;
        flags_q_o <= FLAGS_CLEAR;
      end else if (en_i) begin
        res_q_o   <= res_d_i;
        flags_q_o <= flags_d_i;
      end
    end
  end else begin : g_comb
    logic unused_ctl;
    assign unused_ctl = clk_i ^ rst_i ^ en_i;
    assign res_q_o    = res_d_i;
    assign flags_q_o  = flags_d_i;
  end

endmodule

// File: rtl/sbb_alu.sv
module sbb_alu
  import sbb_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter int HALF_BIT = WIDTH / 2,
  parameter bit REG_OUT  = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic [WIDTH-1:0] dst_i,
  input  logic [WIDTH-1:0] src_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] res_o,
  output logic             c_o,
  output logic             z_o,
  output logic             s_o,
  output logic             v_o,
  output logic             d_o,
  output logic             h_o
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] sum;
  logic             carry_half;
  logic             carry_top;
  sbb_flags_t       flags_d;
  sbb_flags_t       flags_q;

  sbb_addsub_core #(.WIDTH(WIDTH), .HALF_BIT(HALF_BIT)) u_core (
    .a_i          (dst_i),
    .b_i          (src_i),
    .bin_i        (cin_i),
    .sum_o        (sum),
    .carry_half_o (carry_half),
    .carry_top_o  (carry_top)
  );

  sbb_flag_gen #(.WIDTH(WIDTH)) u_flags (
    .dst_msb_i    (dst_i[MSB]),
    .src_msb_i    (src_i[MSB]),
    .sum_i        (sum),
    .carry_half_i (carry_half),
    .carry_top_i  (carry_top),
    .flags_o      (flags_d)
  );

  sbb_out_stage #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_out (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .en_i      (en_i),
    .res_d_i   (sum),
    .flags_d_i (flags_d),
    .res_q_o   (res_o),
    .flags_q_o (flags_q)
  );

  assign c_o = flags_q.c;
  assign z_o = flags_q.z;
  assign s_o = flags_q.s;
  assign v_o = flags_q.v;
  assign d_o = flags_q.d;
  assign h_o = flags_q.h;

endmodule

// File: rtl/sbb_alu_chk.sv
module sbb_alu_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             en_i,
  input logic [WIDTH-1:0] dst_i,
  input logic [WIDTH-1:0] src_i,
  input logic             cin_i,
  input logic [WIDTH-1:0] res_o,
  input logic             c_o,
  input logic             z_o,
  input logic             s_o,
  input logic             v_o,
  input logic             d_o,
  input logic             h_o
);

  logic [WIDTH-1:0] exp_res;
  logic             exp_borrow;
  logic             loaded;

  assign exp_res    = dst_i - src_i - {{(WIDTH-1){1'b0}}, cin_i};
  assign exp_borrow = ({1'b0, dst_i} < ({1'b0, src_i} + {{WIDTH{1'b0}}, cin_i}));

  always_ff @(posedge clk_i) begin
    if (rst_i)     loaded <= 1'b0;
    else if (en_i) loaded <= 1'b1;
  end

  assert_result_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    en_i |=> (res_o == $past(exp_res)));

  assert_borrow_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    en_i |=> (c_o == $past(exp_borrow)));

  assert_zero_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    loaded |-> (z_o == (res_o == '0)));

  assert_sign_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    loaded |-> (s_o == res_o[WIDTH-1]));

  assert_dset_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    en_i |=> d_o);

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> ($stable(res_o) && $stable({c_o, z_o, s_o, v_o, d_o, h_o})));

  assert_reset_R9: assert property (@(posedge clk_i)
    rst_i |=> (res_o == '0 && {c_o, z_o, s_o, v_o, d_o, h_o} == 6'b0));

endmodule

bind sbb_alu sbb_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i (clk_i),
  .rst_i (rst_i),
  .en_i  (en_i),
  .dst_i (dst_i),
  .src_i (src_i),
  .cin_i (cin_i),
  .res_o (res_o),
  .c_o   (c_o),
  .z_o   (z_o),
  .s_o   (s_o),
  .v_o   (v_o),
  .d_o   (d_o),
  .h_o   (h_o)
);

// File: tb/sbb_alu_tb.sv
`timescale 1ns/1ps
module sbb_alu_tb;

  logic       clk_i = 1'b0;
  logic       rst_i = 1'b1;
  logic       en_i  = 1'b0;
  logic [7:0] dst_i = '0;
  logic [7:0] src_i = '0;
  logic       cin_i = 1'b0;
  logic [7:0] res_o;
  logic       c_o, z_o, s_o, v_o, d_o, h_o;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #2.5 clk_i = ~clk_i;
  always @(posedge clk_i) cycles <= cycles + 1;

  sbb_alu u_dut (
    .clk_i (clk_i), .rst_i (rst_i), .en_i (en_i),
    .dst_i (dst_i), .src_i (src_i), .cin_i (cin_i),
    .res_o (res_o), .c_o (c_o), .z_o (z_o), .s_o (s_o),
    .v_o (v_o), .d_o (d_o), .h_o (h_o)
  );

  // Vector layout: dst, src, cin, expected result, expected {c,z,s,v,d,h}
  localparam int NVEC = 12;
  localparam logic [30:0] VEC [NVEC] = '{
    {8'h10, 8'h03, 1'b1, 8'h0C, 6'b000011},
    {8'h20, 8'h8A, 1'b1, 8'h95, 6'b101111},
    {8'h10, 8'h03, 1'b0, 8'h0D, 6'b000011},
    {8'h05, 8'h05, 1'b0, 8'h00, 6'b010010},
    {8'h00, 8'h00, 1'b1, 8'hFF, 6'b101011},
    {8'h80, 8'h01, 1'b0, 8'h7F, 6'b000111},
    {8'h7F, 8'hFF, 1'b0, 8'h80, 6'b101110},
    {8'hFF, 8'hFF, 1'b1, 8'hFF, 6'b101011},
    {8'h00, 8'hFF, 1'b1, 8'h00, 6'b110011},
    {8'h5A, 8'h25, 1'b0, 8'h35, 6'b000010},
    {8'h80, 8'h00, 1'b1, 8'h7F, 6'b000111},
    {8'h3C, 8'h3B, 1'b1, 8'h00, 6'b010010}
  };

  function automatic logic [13:0] model(input int a, input int b, input int c);
    int diff, sdiff, sa, sb, lo;
    logic [7:0] r;
    logic fc, fz, fs, fv, fh;
    diff  = a - b - c;
    r     = diff[7:0];
    sa    = (a > 127) ? a - 256 : a;
    sb    = (b > 127) ? b - 256 : b;
    sdiff = sa - sb - c;
    lo    = (a % 16) - (b % 16) - c;
    fc    = (diff < 0);
    fz    = (r == 8'h00);
    fs    = r[7];
    fv    = (sdiff > 127) || (sdiff < -128);
    fh    = (lo < 0);
    return {r, fc, fz, fs, fv, 1'b1, fh};
  endfunction

  task automatic check(input string req, input logic [13:0] act, input logic [13:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got res=%h flags=%b, expected res=%h flags=%b",
               req, act[13:6], act[5:0], exp[13:6], exp[5:0]);
    end
  endtask

  function automatic logic [13:0] outs();
    return {res_o, c_o, z_o, s_o, v_o, d_o, h_o};
  endfunction

  // Called just after a falling edge; returns just after the next falling edge.
  task automatic apply(input logic [7:0] a, input logic [7:0] b, input logic c, input logic en);
    dst_i = a; src_i = b; cin_i = c; en_i = en;
    @(negedge clk_i);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    wait (cycles >= 190000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got cycles=%0d, expected completion", cycles);
    summary();
  end

  initial begin
    logic [13:0] snap;
    repeat (3) @(negedge clk_i);
    check("R9 reset state", outs(), 14'h0);
    rst_i = 1'b0;
    @(negedge clk_i);

    // Table walk: R1 R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][30:23], VEC[i][22:15], VEC[i][14], 1'b1);
      check("R1 R2 R3 R4 R5 R6 R7 table", outs(), VEC[i][13:0]);
    end

    // Exhaustive sweep against integer model
    for (int c = 0; c < 2; c++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b++) begin
          apply(a[7:0], b[7:0], c[0], 1'b1);
          check("R1 R2 R3 R4 R5 R6 R7 sweep", outs(), model(a, b, c));
        end
      end
    end

    // R8: enable low holds outputs
    apply(8'h20, 8'h8A, 1'b1, 1'b1);
    snap = outs();
    apply(8'h05, 8'h05, 1'b0, 1'b0);
    check("R8 hold with en low", outs(), snap);
    apply(8'h00, 8'h01, 1'b0, 1'b0);
    check("R8 hold second cycle", outs(), snap);

    // R10: new operands not visible before the capturing edge
    dst_i = 8'h10; src_i = 8'h03; cin_i = 1'b1; en_i = 1'b1;
    @(posedge clk_i);
    #0;
    check("R10 before edge", outs(), snap);
    @(negedge clk_i);
    check("R10 after edge", outs(), {8'h0C, 6'b000011});

    // R9: synchronous reset mid-run clears everything
    rst_i = 1'b1;
    apply(8'hFF, 8'h00, 1'b0, 1'b1);
    check("R9 reset mid-run", outs(), 14'h0);
    rst_i = 1'b0;
    apply(8'h00, 8'h01, 1'b0, 1'b1);
    check("R6 R2 after reset", outs(), {8'hFF, 6'b101011});

    summary();
  end

endmodule